// File: doc/BRIEF.md
# Three-Port Digital I/O

This block gives software 24 digital channels, split into three 8-bit ports on a simple register bus. The low port is a fixed output port. Its latch drives the pins and can be read back. The middle port is a fixed input port, and its pin levels are read through a synchronizer. The upper port can be switched between input and output, but only as a whole port. While it is an output it drives its own latch onto the pins. Software reads the upper port's latch at one address and its synchronized pin levels at another.

The pin-side buses follow the combined channel numbering: channels 7:0 are the output port, channels 15:8 are the input port and channels 23:16 are the switchable port. A single-cycle write strobe updates a latch or the direction. A single-cycle read strobe loads the read data register on the next clock edge.

Top module: `dio3_top`

## Requirements
- R1: After reset, both output latches are 0, the switchable port is an input, `dioOe` equals 24'h0000FF, `dioOut` is 0 and `rdData` is 0.
- R2: A write to address 80 loads the low 8 bits of `wrData` into the channel 7:0 latch. That latch appears on `dioOut[7:0]` after the write edge. A read at 80 returns it in `rdData[7:0]`.
- R3: Channels 15:8 are never driven: `dioOe[15:8]` stays 0. A read at 64 returns `dioIn[15:8]` after a two-stage synchronizer. A read issued in the same cycle as a pin change returns the old level. A read issued two or more cycles after the change returns the new level.
- R4: A write to address 224 sets the direction of the whole switchable port. Any nonzero data makes all of channels 23:16 outputs, so `dioOe[23:16]` becomes 8'hFF. Zero makes them all inputs, so `dioOe[23:16]` becomes 8'h00. A read at 224 returns 8'hFF or 8'h00 to match.
- R5: A write to address 112 loads the switchable port's latch in either direction. The latch appears on `dioOut[23:16]`, and a read at 112 returns it.
- R6: A read at 96 returns `dioIn[23:16]` through the same two-stage synchronizer, in either direction.
- R7: Writes to the input addresses 64 and 96, and to unmapped addresses, change no latch, no direction and no pin output.
- R8: A read at an unmapped address returns 0. On every read, `rdData[31:8]` is 0.
- R9: `rdData` changes only on the clock edge that takes a read. Without a read it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 32 | Registered read data |
| dioIn | input | 16 | Pin levels of channels 23:8 |
| dioOut | output | 24 | Pin output values, channels 23:0 |
| dioOe | output | 24 | Pin output enables, channels 23:0 |

## Verification
The bench builds the block with its default parameters: 8-bit ports, a 32-bit read bus and two synchronizer stages. Because there are only two stages, the bench can name the exact cycle in which a pin change first becomes readable, and it checks both the stale read and the first fresh read. The default address map places the read-only input addresses next to the writable ones, so the bench can write to 64 and 96 and confirm that nothing changes.

// File: rtl/dio3_pkg.sv
package dio3_pkg;
  typedef enum logic [2:0] {
    RD_NONE  = 3'd0,
    RD_P0    = 3'd1,
    RD_P1    = 3'd2,
    RD_P2OUT = 3'd3,
    RD_P2IN  = 3'd4,
    RD_DIR   = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic   wrP0;
    logic   wrP2;
    logic   wrDir;
    logic   rdStb;
    rdSel_e rdSel;
  } dioStrobe_t;
endpackage

// File: rtl/dio3_ctrl.sv
module dio3_ctrl
  import dio3_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ADR_P0    = 80,
  parameter int ADR_P1IN  = 64,
  parameter int ADR_P2OUT = 112,
  parameter int ADR_P2IN  = 96,
  parameter int ADR_DIR   = 224
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output dioStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_P0    = ADDR_W'(ADR_P0);
  localparam logic [ADDR_W-1:0] A_P1IN  = ADDR_W'(ADR_P1IN);
  localparam logic [ADDR_W-1:0] A_P2OUT = ADDR_W'(ADR_P2OUT);
  localparam logic [ADDR_W-1:0] A_P2IN  = ADDR_W'(ADR_P2IN);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(ADR_DIR);

  always_comb begin
    strb       = '0;
    strb.wrP0  = wrEn && (addr == A_P0);
    strb.wrP2  = wrEn && (addr == A_P2OUT);
    strb.wrDir = wrEn && (addr == A_DIR);
    strb.rdStb = rdEn;
    strb.rdSel = RD_NONE;
    if (rdEn) begin
      unique case (addr)
        A_P0:    strb.rdSel = RD_P0;
        A_P1IN:  strb.rdSel = RD_P1;
        A_P2OUT: strb.rdSel = RD_P2OUT;
        A_P2IN:  strb.rdSel = RD_P2IN;
        A_DIR:   strb.rdSel = RD_DIR;
        default: strb.rdSel = RD_NONE;
      endcase
    end
  end

  // R7: at most one write strobe per cycle, and none without a bus write
  a_r7_ctrl_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrP0, strb.wrP2, strb.wrDir}));
  a_r7_no_write_without_wren: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.wrP0 || strb.wrP2 || strb.wrDir));
endmodule

// File: rtl/dio3_datapath.sv
module dio3_datapath
  import dio3_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dioStrobe_t               strb,
  input  logic [PORT_W-1:0]        wrData,
  input  logic [3*PORT_W-1:PORT_W] dioIn,
  output logic [3*PORT_W-1:0]      dioOut,
  output logic [3*PORT_W-1:0]      dioOe,
  output logic [DATA_W-1:0]        rdData
);
  localparam int IN_W  = 2 * PORT_W;
  localparam int PAD_W = DATA_W - PORT_W;

  logic [PORT_W-1:0] p0Latch;
  logic [PORT_W-1:0] p2Latch;
  logic              p2IsOut;
  logic [SYNC_STAGES-1:0][IN_W-1:0] syncQ;
  logic [IN_W-1:0]   inSync;
  logic [PORT_W-1:0] rdByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p0Latch <= '0;
      p2Latch <= '0;
      p2IsOut <= 1'b0;
    end else begin
      if (strb.wrP0)  p0Latch <= wrData;
      if (strb.wrP2)  p2Latch <= wrData;
      if (strb.wrDir) p2IsOut <= |wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= dioIn;
  end

  genvar gs;
  generate
    for (gs = 1; gs < SYNC_STAGES; gs++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[gs] <= '0;
        else       syncQ[gs] <= syncQ[gs-1];
      end
    end
  endgenerate

  assign inSync = syncQ[SYNC_STAGES-1];

  always_comb begin
    unique case (strb.rdSel)
      RD_P0:    rdByte = p0Latch;
      RD_P1:    rdByte = inSync[PORT_W-1:0];
      RD_P2OUT: rdByte = p2Latch;
      RD_P2IN:  rdByte = inSync[IN_W-1:PORT_W];
      RD_DIR:   rdByte = {PORT_W{p2IsOut}};
      default:  rdByte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdStb) rdData <= {{PAD_W{1'b0}}, rdByte};
  end

  assign dioOut = {p2Latch, {PORT_W{1'b0}}, p0Latch};
  assign dioOe  = {{PORT_W{p2IsOut}}, {PORT_W{1'b0}}, {PORT_W{1'b1}}};

  a_r2_p0_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrP0 |=> dioOut[PORT_W-1:0] == $past(wrData));
  a_r5_p2_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrP2 |=> dioOut[3*PORT_W-1:2*PORT_W] == $past(wrData));
  a_r4_dir_whole_port: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDir && wrData != '0) |=> dioOe[3*PORT_W-1:2*PORT_W] == {PORT_W{1'b1}});
  a_r7_p0_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrP0 |=> $stable(dioOut[PORT_W-1:0]));
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStb |=> $stable(rdData));
endmodule

// File: rtl/dio3_top.sv
module dio3_top
  import dio3_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [PORT_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic [3*PORT_W-1:PORT_W] dioIn,
  output logic [3*PORT_W-1:0]      dioOut,
  output logic [3*PORT_W-1:0]      dioOe
);
  dioStrobe_t strb;

  dio3_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  dio3_datapath #(.PORT_W(PORT_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .dioIn(dioIn),
    .dioOut(dioOut), .dioOe(dioOe), .rdData(rdData)
  );
endmodule

// File: tb/tb_dio3_top.sv
module tb_dio3_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [31:0] rdData;
  logic [23:8] dioIn = '0;
  logic [23:0] dioOut;
  logic [23:0] dioOe;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdPend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dio3_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .dioIn(dioIn), .dioOut(dioOut), .dioOe(dioOe)
  );

  always @(posedge clk) rdPend <= rdEn;

  // monitor: compares each read result against the scoreboard
  always @(negedge clk) begin
    if (rdPend) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (rdData !== e) begin
        nFails++;
        $display("FAIL %s: rdData actual %h expected %h", t, rdData, e);
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkVal(input string t, input logic [31:0] act, input logic [31:0] e);
    nChecks++;
    if (act !== e) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkVal("R1 oe", {8'h0, dioOe}, 32'h0000_00FF);
    checkVal("R1 out", {8'h0, dioOut}, 32'h0);
    checkVal("R1 rdData", rdData, 32'h0);
    busRead(8'd80, 32'h0, "R1 p0 latch");
    busRead(8'd112, 32'h0, "R1 p2 latch");
    busRead(8'd224, 32'h0, "R1 dir");

    // R2 output port
    busWrite(8'd80, 8'hA5);
    checkVal("R2 pins", {24'h0, dioOut[7:0]}, 32'hA5);
    busRead(8'd80, 32'hA5, "R2 readback");
    busWrite(8'd80, 8'h3C);
    busRead(8'd80, 32'h3C, "R2 second value");

    // R3 input port with synchronizer latency
    checkVal("R3 oe", {24'h0, dioOe[15:8]}, 32'h0);
    dioIn[15:8] = 8'h96;
    busRead(8'd64, 32'h00, "R3 stale read");
    @(negedge clk);
    busRead(8'd64, 32'h96, "R3 synced read");
    dioIn[15:8] = 8'h0F;
    repeat (2) @(negedge clk);
    busRead(8'd64, 32'h0F, "R3 second pattern");

    // R4 whole-port direction
    busWrite(8'd224, 8'h04);
    checkVal("R4 oe out", {24'h0, dioOe[23:16]}, 32'hFF);
    busRead(8'd224, 32'hFF, "R4 dir readback out");
    busWrite(8'd224, 8'h00);
    checkVal("R4 oe in", {24'h0, dioOe[23:16]}, 32'h00);
    busRead(8'd224, 32'h00, "R4 dir readback in");

    // R5 latch while input, R6 input levels
    busWrite(8'd112, 8'h5A);
    checkVal("R5 pins", {24'h0, dioOut[23:16]}, 32'h5A);
    busRead(8'd112, 32'h5A, "R5 readback as input");
    dioIn[23:16] = 8'hC3;
    repeat (2) @(negedge clk);
    busRead(8'd96, 32'hC3, "R6 input levels as input");
    busWrite(8'd224, 8'h80);
    busWrite(8'd112, 8'h81);
    busRead(8'd112, 32'h81, "R5 readback as output");
    busRead(8'd96, 32'hC3, "R6 input levels as output");

    // R7 writes to read-only and unmapped addresses
    busWrite(8'd64, 8'h11);
    busWrite(8'd96, 8'h22);
    busWrite(8'd0, 8'h33);
    checkVal("R7 pins", {8'h0, dioOut}, 32'h0081_003C);
    checkVal("R7 oe", {8'h0, dioOe}, 32'h00FF_00FF);
    busRead(8'd80, 32'h3C, "R7 p0 unchanged");
    busRead(8'd112, 32'h81, "R7 p2 unchanged");
    busRead(8'd224, 32'hFF, "R7 dir unchanged");
    busRead(8'd64, 32'h0F, "R7 p1 read unaffected");

    // R8 unmapped reads
    busRead(8'd0, 32'h0, "R8 addr 0");
    busRead(8'd81, 32'h0, "R8 addr 81");

    // R9 hold without read
    busRead(8'd80, 32'h3C, "R9 load");
    busWrite(8'd80, 8'hE7);
    repeat (3) @(negedge clk);
    checkVal("R9 hold", rdData, 32'h3C);

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule